// File: doc/BRIEF.md
# Status Register with Transition Filters

This block is one cell of an instrument's status-reporting tree. It takes a live condition vector, looks for changes in each bit from one clock to the next, and keeps only the changes selected by two per-bit masks. One mask passes rising changes and the other passes falling changes. A change that passes is latched into a sticky event vector. The event vector is ANDed with an enable mask and the results are ORed into one registered summary bit, which feeds a bit of the next register up the tree.

A controller reaches the cell through a small register port. It can write and read the rising mask, the falling mask and the enable mask, read the condition vector as it is at that moment, and read the event vector. Reading the event vector clears it in the same access. A preset strobe puts the masks into their default state. A clear strobe empties the event vector and leaves the masks alone.

Top module: `status_cell`

## Requirements
- R1: After reset the rising mask is all ones, the falling mask is zero, the event vector is zero, summary is 0 and rdata is 0. The enable mask is zero when ENA_FILL=0 and all ones when ENA_FILL=1.
- R2: A 0-to-1 change of a condition bit between two clocks sets the matching event bit only if the matching rising-mask bit (address 1) is 1.
- R3: A 1-to-0 change of a condition bit sets the matching event bit only if the matching falling-mask bit (address 2) is 1.
- R4: Event bits stay set after the condition changes back. Only a read of the event vector or a clear strobe resets them.
- R5: A read at address 3 places the event vector on rdata one clock later and clears it. An edge that passes a filter in the same cycle as the read stays set afterwards.
- R6: Reads at addresses 1, 2 and 4 do not change the masks, and the masks can be written at any time. Writes to address 0 (condition) and address 3 (event) have no effect.
- R7: summary is registered. It equals the OR over all bits of (event AND enable) as it stood one clock earlier. The enable mask is at address 4.
- R8: The preset strobe sets the rising mask to all ones, clears the falling mask, clears the enable mask (or fills it with ones when ENA_FILL=1), and leaves the event vector as it is. Preset takes priority over a write in the same cycle.
- R9: The clear strobe resets the event vector to zero and leaves all three masks unchanged.
- R10: A read at address 0 returns the condition input as sampled at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | WIDTH | Live condition vector |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address: 0 condition, 1 rising mask, 2 falling mask, 3 event, 4 enable |
| wdata | input | WIDTH | Write data |
| preset | input | 1 | Puts the masks into their default state |
| clear | input | 1 | Clears the event vector |
| rdata | output | WIDTH | Registered read data |
| summary | output | 1 | Registered summary bit |

## Verification
The bench builds two instances that share all inputs. The main one uses WIDTH=16 and ENA_FILL=0 and is used for the whole filter, latch, read-clear and summary behaviour. The second uses ENA_FILL=1. It is checked only for the enable mask after reset and after preset, which brings the fill-with-ones preset variant within reach of the checks.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    A_COND = 3'd0,
    A_RISE = 3'd1,
    A_FALL = 3'd2,
    A_EVT  = 3'd3,
    A_ENA  = 3'd4
  } stat_addr_e;
endpackage

// File: rtl/stat_edge_detect.sv
module stat_edge_detect #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] cond_i,
  input  logic [WIDTH-1:0] rise_m,
  input  logic [WIDTH-1:0] fall_m,
  output logic [WIDTH-1:0] pass_o
);
  logic [WIDTH-1:0] prev_q;

  // On reset, prev takes the live value so no edge is seen when reset ends
  always_ff @(posedge clk) begin
    prev_q <= cond_i;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign pass_o[i] = (cond_i[i] & ~prev_q[i] & rise_m[i]) |
                       (~cond_i[i] & prev_q[i] & fall_m[i]);
  end

  // R2 / R3: nothing passes unless the bit actually changed
  a_r2_no_pass_without_change: assert property (@(posedge clk) disable iff (rst)
    ((pass_o & ~(cond_i ^ prev_q)) == '0));
endmodule

// File: rtl/stat_event_reg.sv
module stat_event_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] set_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] evt_o
);
  always_ff @(posedge clk) begin
    if (rst)        evt_o <= '0;
    else if (clr_i) evt_o <= set_i;
    else            evt_o <= evt_o | set_i;
  end

  // R5 / R9: after a clear only bits set in that same cycle remain
  a_r5_clear_keeps_new: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> ((evt_o & ~$past(set_i)) == '0));
  // R4: without a clear, set bits stay set
  a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> ((evt_o & $past(evt_o)) == $past(evt_o)));
endmodule

// File: rtl/stat_mask_regs.sv
module stat_mask_regs
  import stat_pkg::*;
#(
  parameter int WIDTH    = 16,
  parameter bit ENA_FILL = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             preset,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o,
  output logic [WIDTH-1:0] ena_o
);
  localparam logic [WIDTH-1:0] ENA_DEF = ENA_FILL ? {WIDTH{1'b1}} : '0;

  always_ff @(posedge clk) begin
    if (rst || preset) begin
      rise_o <= '1;
      fall_o <= '0;
      ena_o  <= ENA_DEF;
    end else if (wr_en) begin
      if (addr == A_RISE) rise_o <= wdata;
      if (addr == A_FALL) fall_o <= wdata;
      if (addr == A_ENA)  ena_o  <= wdata;
    end
  end

  // R8: preset result
  a_r8_preset: assert property (@(posedge clk) disable iff (rst)
    preset |=> (rise_o == '1 && fall_o == '0 && ena_o == ENA_DEF));
  // R6: masks hold unless written or preset
  a_r6_rise_hold: assert property (@(posedge clk) disable iff (rst)
    (!preset && !(wr_en && addr == A_RISE)) |=> $stable(rise_o));
  a_r6_fall_hold: assert property (@(posedge clk) disable iff (rst)
    (!preset && !(wr_en && addr == A_FALL)) |=> $stable(fall_o));
endmodule

// File: rtl/status_cell.sv
module status_cell
  import stat_pkg::*;
#(
  parameter int WIDTH    = 16,
  parameter bit ENA_FILL = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] cond_i,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [2:0]       addr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             preset,
  input  logic             clear,
  output logic [WIDTH-1:0] rdata,
  output logic             summary
);
  logic [WIDTH-1:0] rise_m, fall_m, ena_m, pass_v, evt_v;
  logic             rd_clr;

  assign rd_clr = rd_en && (addr == A_EVT);

  stat_mask_regs #(.WIDTH(WIDTH), .ENA_FILL(ENA_FILL)) u_masks (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .preset(preset), .rise_o(rise_m), .fall_o(fall_m), .ena_o(ena_m)
  );

  stat_edge_detect #(.WIDTH(WIDTH)) u_edge (
    .clk(clk), .rst(rst), .cond_i(cond_i), .rise_m(rise_m),
    .fall_m(fall_m), .pass_o(pass_v)
  );

  stat_event_reg #(.WIDTH(WIDTH)) u_evt (
    .clk(clk), .rst(rst), .set_i(pass_v), .clr_i(rd_clr | clear),
    .evt_o(evt_v)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      summary <= 1'b0;
    end else begin
      summary <= |(evt_v & ena_m);
      if (rd_en) begin
        unique case (addr)
          A_COND:  rdata <= cond_i;
          A_RISE:  rdata <= rise_m;
          A_FALL:  rdata <= fall_m;
          A_EVT:   rdata <= evt_v;
          A_ENA:   rdata <= ena_m;
          default: rdata <= '0;
        endcase
      end
    end
  end

  // R7: summary follows enabled events with one clock of lag
  a_r7_summary: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (summary == $past(|(evt_v & ena_m))));
  // R5: an event read returns the pre-clear contents
  a_r5_read_value: assert property (@(posedge clk) disable iff (rst)
    rd_clr |=> (rdata == $past(evt_v)));
endmodule

// File: tb/tb_status_cell.sv
module tb_status_cell;
  localparam int W = 16;
  logic clk = 1'b0, rst = 1'b1;
  logic [W-1:0] cond_i = '0, wdata = '0;
  logic wr_en = 0, rd_en = 0, preset = 0, clear = 0;
  logic [2:0] addr = '0;
  logic [W-1:0] rdata, rdata1;
  logic summary, summary1;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  status_cell #(.WIDTH(W), .ENA_FILL(1'b0)) dut (
    .clk(clk), .rst(rst), .cond_i(cond_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .preset(preset), .clear(clear),
    .rdata(rdata), .summary(summary));

  status_cell #(.WIDTH(W), .ENA_FILL(1'b1)) dut_fill (
    .clk(clk), .rst(rst), .cond_i(cond_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .preset(preset), .clear(clear),
    .rdata(rdata1), .summary(summary1));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a);
    rd_en = 1; addr = a; tick(); rd_en = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    wr_en = 1; addr = a; wdata = d; tick(); wr_en = 0;
  endtask

  task automatic t_reset();
    rd(3'd1); chk("R1 rise", rdata, 16'hffff);
    rd(3'd2); chk("R1 fall", rdata, 16'h0000);
    rd(3'd4); chk("R1 ena", rdata, 16'h0000); chk("R1 ena fill", rdata1, 16'hffff);
    rd(3'd3); chk("R1 evt", rdata, 16'h0000);
    chk("R1 summary", {15'd0, summary}, 16'd0);
  endtask

  task automatic t_rise();
    wr(3'd1, 16'h00ff);
    cond_i = 16'h0101; tick();
    rd(3'd3); chk("R2 rise filtered", rdata, 16'h0001);
    rd(3'd3); chk("R5 read cleared", rdata, 16'h0000);
  endtask

  task automatic t_fall();
    wr(3'd2, 16'h0100);
    cond_i = 16'h0000; tick();
    rd(3'd3); chk("R3 fall filtered", rdata, 16'h0100);
  endtask

  task automatic t_sticky();
    wr(3'd2, 16'h0000);
    cond_i = 16'h0004; tick();
    cond_i = 16'h0000; tick(); tick(); tick();
    rd(3'd3); chk("R4 sticky", rdata, 16'h0004);
  endtask

  task automatic t_summary();
    wr(3'd4, 16'h0008);
    cond_i = 16'h0004; tick(); tick();
    chk("R7 disabled bit", {15'd0, summary}, 16'd0);
    wr(3'd4, 16'h0004); tick();
    chk("R7 enabled bit", {15'd0, summary}, 16'd1);
    rd(3'd3); tick();
    chk("R7 falls after clear", {15'd0, summary}, 16'd0);
    cond_i = 16'h0000; wr(3'd4, 16'h0000);
  endtask

  task automatic t_read_edge();
    cond_i = 16'h0001; tick();
    cond_i = 16'h0003; rd(3'd3);
    chk("R5 read old value", rdata, 16'h0001);
    rd(3'd3); chk("R5 same-cycle edge kept", rdata, 16'h0002);
    cond_i = 16'h0000; tick(); rd(3'd3);
  endtask

  task automatic t_masks();
    wr(3'd2, 16'h1234);
    rd(3'd2); rd(3'd2); chk("R6 read nondestructive", rdata, 16'h1234);
    wr(3'd3, 16'hffff); wr(3'd0, 16'hffff);
    rd(3'd3); chk("R6 event write ignored", rdata, 16'h0000);
    cond_i = 16'h5a5a; rd(3'd0); chk("R10 cond live", rdata, 16'h5a5a);
    cond_i = 16'h0000; tick(); rd(3'd3);
  endtask

  task automatic t_clear();
    cond_i = 16'h0010; tick();
    clear = 1; tick(); clear = 0;
    rd(3'd3); chk("R9 event cleared", rdata, 16'h0000);
    rd(3'd2); chk("R9 fall kept", rdata, 16'h1234);
    rd(3'd1); chk("R9 rise kept", rdata, 16'h00ff);
  endtask

  task automatic t_preset();
    wr(3'd4, 16'h00f0);
    cond_i = 16'h0030; tick();
    preset = 1; wr_en = 1; addr = 3'd2; wdata = 16'hbeef; tick();
    preset = 0; wr_en = 0;
    rd(3'd1); chk("R8 rise ones", rdata, 16'hffff);
    rd(3'd2); chk("R8 fall zero, preset beats write", rdata, 16'h0000);
    rd(3'd4); chk("R8 ena zero", rdata, 16'h0000); chk("R8 ena fill ones", rdata1, 16'hffff);
    rd(3'd3); chk("R8 event untouched", rdata, 16'h0020);
  endtask

  initial begin
    repeat (3) tick();
    rst = 0; tick();
    t_reset(); t_rise(); t_fall(); t_sticky(); t_summary();
    t_read_edge(); t_masks(); t_clear(); t_preset();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule